// File: doc/BRIEF.md
# Millisecond Interval Countdown Timer

This block turns a program-supplied period into a repeating "interval done" event. The period arrives as a 36-bit value in units of the fast hardware tick. The block rounds it up to a whole number of milliseconds. One millisecond is 4096 ticks, so the low 12 bits of the written value are the sub-millisecond part.

A shared 12-bit tick counter lives outside this block. Each time that counter wraps, it sends a one-cycle overflow strobe here. The block counts down in whole-millisecond steps on those strobes only. When the count runs out, the block sets a sticky done flag and emits a one-cycle interrupt request. It then reloads the countdown from the stored period, so the event repeats.

The write port follows valid/ready rules. A value is taken in any cycle in which `wr_valid` and `wr_ready` are both high. The block never applies back-pressure, so `wr_ready` is always high once reset is released. A source may therefore hold `wr_valid` for exactly one cycle per value. The raw value last accepted is always visible on the read port. The done flag stays set until the owner pulses the clear input.

Top module: `ms_interval_timer`

## Requirements
- R1: A write is split into two parts: bits 35:12 give whole milliseconds, and bits 11:0 give ticks. The stored period is the written value with bits 11:0 cleared, plus 4096 if any of bits 11:0 was one. This means the done event comes after ceil(value/4096) overflow strobes.
- R2: A write of value zero rounds to zero and is ignored. The read value, the countdown and the done flag are left as they were.
- R3: After an accepted write, `rd_data` shows exactly the raw value written, from the next cycle on.
- R4: An accepted write loads the time-to-go with the rounded period. Each later overflow strobe lowers it by 4096. The done flag is set on the strobe that brings it to zero or below.
- R5: The first decrement after a write happens on the next overflow strobe, however many cycles later it comes. If an overflow strobe coincides with an accepted write, the write wins and that strobe does not decrement.
- R6: When the done event fires, the time-to-go reloads from the stored period. With no further writes, events then repeat every N strobes, where N is the rounded period divided by 4096.
- R7: `done_o` stays set until a `done_clr` pulse clears it. If a clear and a new done event fall in the same cycle, the flag ends up set.
- R8: Each done event raises `irq_o` for exactly one cycle, in the same cycle that `done_o` is first seen set by it.
- R9: After reset and before the first accepted nonzero write, overflow strobes have no effect. During that time `done_o` and `irq_o` stay low.
- R10: Reset leaves `done_o` low, `irq_o` low and `rd_data` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write value offered |
| wr_ready | output | 1 | Write value can be taken (always high after reset) |
| wr_data | input | 36 | Period to load, in hardware ticks |
| rd_data | output | 36 | Raw value of the last accepted write |
| tick_ovf | input | 1 | One-cycle strobe when the 12-bit tick counter wraps |
| done_clr | input | 1 | One-cycle strobe that clears the done flag |
| done_o | output | 1 | Sticky interval-done flag |
| irq_o | output | 1 | One-cycle interrupt request per done event |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a period write and a counter overflow. The bench provokes this by driving both strobes in one cycle partway through a countdown. It then counts how many further strobes are needed before the interrupt: the full new period means the write won. The second pair is a flag clear and a fresh done event. The bench raises the clear on the very strobe that expires the count, then expects the flag still set and a single interrupt pulse.

// File: rtl/ms_interval_timer_pkg.sv
package ms_interval_timer_pkg;
  localparam int unsigned ITM_DATA_W_DEF = 36;
  localparam int unsigned ITM_TICK_W_DEF = 12;

  typedef enum logic [1:0] {
    CD_IDLE = 2'd0,
    CD_LOAD = 2'd1,
    CD_STEP = 2'd2
  } cd_op_e;
endpackage

// File: rtl/ms_interval_round.sv
module ms_interval_round #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned TICK_W = 12,
  localparam int unsigned P_W   = DATA_W + 1
) (
  input  logic [DATA_W-1:0] raw_i,
  output logic [P_W-1:0]    period_o,
  output logic              is_zero_o
);
  localparam logic [P_W-1:0] STEP = P_W'(1) << TICK_W;

  logic [P_W-1:0] whole_ms;
  logic           frac_nz;

  always_comb begin
    whole_ms  = {1'b0, raw_i[DATA_W-1:TICK_W], {TICK_W{1'b0}}};
    frac_nz   = |raw_i[TICK_W-1:0];
    period_o  = whole_ms + (frac_nz ? STEP : '0);
    is_zero_o = (period_o == '0);
  end
endmodule

// File: rtl/ms_interval_countdown.sv
module ms_interval_countdown
  import ms_interval_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned TICK_W = 12,
  localparam int unsigned P_W   = DATA_W + 1,
  localparam int unsigned T_W   = DATA_W + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [P_W-1:0] period_i,
  input  logic           tick_i,
  output logic           expire_o,
  output logic           armed_o
);
  localparam logic [T_W-1:0] STEP = T_W'(1) << TICK_W;

  logic [P_W-1:0] period_q;
  logic [T_W-1:0] ttg_q;
  logic [T_W-1:0] ttg_dec;
  logic           armed_q;
  cd_op_e         op;

  always_comb begin
    if (load_i)                op = CD_LOAD;
    else if (tick_i && armed_q) op = CD_STEP;
    else                       op = CD_IDLE;
    ttg_dec  = ttg_q - STEP;
    expire_o = (op == CD_STEP) && (ttg_dec[T_W-1] || (ttg_dec == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      ttg_q    <= '0;
      armed_q  <= 1'b0;
    end else begin
      unique case (op)
        CD_LOAD: begin
          period_q <= period_i;
          ttg_q    <= {1'b0, period_i};
          armed_q  <= 1'b1;
        end
        CD_STEP: ttg_q <= expire_o ? {1'b0, period_q} : ttg_dec;
        default: ;
      endcase
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/ms_interval_flag.sv
module ms_interval_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic done_o,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= set_i;
      if (set_i)      done_o <= 1'b1;
      else if (clr_i) done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer
  import ms_interval_timer_pkg::*;
#(
  parameter int unsigned DATA_W = ITM_DATA_W_DEF,
  parameter int unsigned TICK_W = ITM_TICK_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick_ovf,
  input  logic              done_clr,
  output logic              done_o,
  output logic              irq_o
);
  localparam int unsigned P_W = DATA_W + 1;

  logic [P_W-1:0]    rounded;
  logic              rounded_zero;
  logic              accept;
  logic              expire;
  logic              cd_armed;
  logic [DATA_W-1:0] raw_q;
  logic              ready_q;

  ms_interval_round #(.DATA_W(DATA_W), .TICK_W(TICK_W)) u_round (
    .raw_i     (wr_data),
    .period_o  (rounded),
    .is_zero_o (rounded_zero)
  );

  assign accept = wr_valid && wr_ready && !rounded_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (accept) raw_q <= wr_data;
    end
  end

  assign wr_ready = ready_q;
  assign rd_data  = raw_q;

  ms_interval_countdown #(.DATA_W(DATA_W), .TICK_W(TICK_W)) u_cd (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .period_i (rounded),
    .tick_i   (tick_ovf),
    .expire_o (expire),
    .armed_o  (cd_armed)
  );

  ms_interval_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (expire),
    .clr_i  (done_clr),
    .done_o (done_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/ms_interval_timer_chk.sv
module ms_interval_timer_chk #(
  parameter int unsigned DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              tick_ovf,
  input logic              done_clr,
  input logic              done_o,
  input logic              irq_o,
  input logic              armed
);
  // R2: a zero write leaves the readback untouched
  p_zero_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_data == '0) |=> $stable(rd_data));

  // R3: the accepted raw value appears on the read port
  p_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_data != '0) |=> (rd_data == $past(wr_data)));

  // R4: a new done event only follows an overflow strobe
  p_set_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(tick_ovf));

  // R5: a write cycle never produces an event
  p_write_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_data != '0) |=> !irq_o);

  // R7: the flag holds without a clear
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !done_clr) |=> done_o);

  // R8: interrupt pulse goes with the flag
  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done_o);
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> irq_o);

  // R9: nothing happens before the first valid period
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!done_o && !irq_o));
endmodule

bind ms_interval_timer ms_interval_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .tick_ovf (tick_ovf),
  .done_clr (done_clr),
  .done_o   (done_o),
  .irq_o    (irq_o),
  .armed    (cd_armed)
);

// File: tb/ms_interval_timer_bench.sv
module ms_interval_timer_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          tick_ovf = 1'b0;
  logic          done_clr = 1'b0;
  logic          done_o;
  logic          irq_o;

  int tests = 0;
  int fails = 0;

  // bench model
  longint        ovf_count = 0;
  longint        n_ms = 0;
  longint        remain = 0;
  bit            armed = 0;
  bit            exp_done = 0;
  logic [DW-1:0] exp_raw = '0;
  longint        exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ms_interval_timer u_ms_interval_timer (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_data(rd_data), .tick_ovf(tick_ovf),
    .done_clr(done_clr), .done_o(done_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint round_ms(input logic [DW-1:0] v);
    longint r;
    r = longint'(v >> 12);
    if (v[11:0] != 0) r++;
    return r;
  endfunction

  // driver: one cycle of stimulus, model updated and expectations pushed
  task automatic step(input bit ovf, input bit wr, input logic [DW-1:0] d, input bit clr);
    bit set_now = 0;
    wr_valid = wr; wr_data = d; tick_ovf = ovf; done_clr = clr;
    if (ovf) ovf_count++;
    if (wr && round_ms(d) != 0) begin
      n_ms = round_ms(d); remain = n_ms; armed = 1; exp_raw = d;
    end else if (ovf && armed) begin
      remain--;
      if (remain == 0) begin
        set_now = 1; remain = n_ms; exp_q.push_back(ovf_count);
      end
    end
    if (set_now) exp_done = 1;
    else if (clr) exp_done = 0;
    @(negedge clk);
    wr_valid = 0; tick_ovf = 0; done_clr = 0;
  endtask

  task automatic ovfs(input int n);
    for (int i = 0; i < n; i++) step(1, 0, '0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0);
  endtask

  task automatic check_state(input string req);
    check({req, " done"}, done_o, exp_done);
    check({req, " rd_data"}, rd_data, exp_raw);
  endtask

  // monitor: every interrupt pulse must match the next expected overflow index
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && irq_o) begin
        if (exp_q.size() == 0) check("R8 unexpected irq", 1, 0);
        else check("R6 irq at overflow", ovf_count, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    check("R10 done", done_o, 0);
    check("R10 irq", irq_o, 0);
    check("R10 rd_data", rd_data, 0);
    check("R10 wr_ready", wr_ready, 1);
    // R9: overflows before any period do nothing
    ovfs(5);
    check_state("R9");
    // R2: zero write ignored
    step(0, 1, '0, 0);
    ovfs(3);
    check_state("R2 zero write");
    // R1/R4: exact 3 ms
    step(0, 1, 36'd12288, 0);
    check_state("R3 readback exact");
    ovfs(2);
    check_state("R4 before expiry");
    ovfs(1);
    check_state("R4 expiry");
    // R6 + R7: repeat, sticky
    ovfs(3);
    check_state("R7 sticky");
    step(0, 0, '0, 1);
    check_state("R7 clear");
    // R1: 2 ms + 1 tick rounds to 3
    step(0, 1, 36'd8193, 0);
    check_state("R3 readback odd");
    ovfs(2);
    check_state("R1 not yet");
    ovfs(1);
    check_state("R1 rounded up");
    step(0, 0, '0, 1);
    // R2: zero write mid countdown changes nothing
    ovfs(1);
    step(0, 1, '0, 0);
    ovfs(1);
    check_state("R2 mid countdown");
    ovfs(1);
    check_state("R2 period kept");
    step(0, 0, '0, 1);
    // R1: tiny value rounds to 1 ms; R5 phase independence
    step(0, 1, 36'd5, 0);
    idle(7);
    check_state("R5 idle phase");
    ovfs(1);
    check_state("R5 first ovf");
    step(0, 0, '0, 1);
    // R5: write coinciding with overflow
    step(0, 1, 36'd8192, 0);
    ovfs(1);
    step(1, 1, 36'd8192, 0);
    ovfs(1);
    check_state("R5 write wins");
    ovfs(1);
    check_state("R5 full period");
    // R7: clear and set together keep flag set
    step(0, 0, '0, 1);
    ovfs(1);
    step(1, 0, '0, 1);
    check_state("R7 clear vs set");
    // large value readback
    step(0, 1, 36'hFFFFFFFFF, 0);
    check_state("R3 max value");
    idle(3);
    check("R6 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule